// File: doc/BRIEF.md
# Modem Handshake Line Controller

This block looks after the six modem handshake wires of a single serial channel. Two of them are active-low outputs, terminal-ready and request-to-send. Each is turned on by its own bit in a small control register. A loopback control input overrides both bits and parks the two wires at their idle (high) level. The other four wires are active-low inputs: set-ready, clear-to-send, carrier-detect and ring. They are resynchronised into the block's clock domain, and each is watched for changes.

A status register shows the present level of each input, inverted so that 1 means asserted. It also holds a sticky change flag for each input. The set-ready, clear-to-send and carrier-detect flags latch on a transition in either direction. The ring flag latches only when ring goes from asserted to released. Reading the status register clears all four flags. A change that arrives in the same cycle as that read is kept, so the event is not lost. An interrupt request is raised while any flag is set and the interrupt enable bit in the control register is on.

Software uses one read/write register port. Address 0 is the control register and address 1 is the status register. Reads are combinational on the selected address. A status read takes effect on the clock edge that ends the cycle in which the read strobe is high.

Top module: `mdm_handshake_unit`

## Requirements
- R1: After synchronous reset, the control register reads 0, terminal-ready and request-to-send are high, irq is low, and every status change flag is 0.
- R2: Control bit 0 set drives term_rdy_n low, and control bit 1 set drives req_send_n low, while loopback is low. A cleared bit leaves its output high.
- R3: While loopback is high, term_rdy_n and req_send_n are both high whatever the control bits hold. The control register keeps its value and reads it back unchanged.
- R4: Status bits [7:4] show the inverted levels of clear-to-send (bit 4), set-ready (bit 5), ring (bit 6) and carrier-detect (bit 7). A new input level is visible after two rising clock edges.
- R5: The change flags for clear-to-send (bit 0), set-ready (bit 1) and carrier-detect (bit 3) set on a rising or a falling input. The flag becomes visible on the third rising edge after the input changes.
- R6: The ring change flag (bit 2) sets only when ring_n goes from low to high. A high-to-low change of ring_n leaves it clear.
- R7: A read of address 1 clears all four change flags at the clock edge that ends the read cycle.
- R8: A flag whose input edge is detected in the same cycle as a status read stays set after that read.
- R9: irq is high exactly when control bit 2 (interrupt enable) is 1 and at least one change flag is set.
- R10: Control bits [7:3] read as 0. A write to address 1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags when address is 1) |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 3 | Write data for control bits [2:0] |
| reg_rdata | output | 8 | Read data of the addressed register |
| loopback | input | 1 | Forces both handshake outputs high |
| dsr_n | input | 1 | Set-ready, active low |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier-detect, active low |
| ring_n | input | 1 | Ring, active low |
| term_rdy_n | output | 1 | Terminal-ready, active low |
| req_send_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong internal state shows up at the ports in a fixed number of cycles. A bad synchronizer stage shows on the status level bits off by one edge, two edges after an input changes. A bad previous-value flop or edge rule shows as a missing or extra change flag three edges after the change. That flag is also visible on irq in the same cycle when the enable bit is on. A flag that is cleared wrongly shows on the very next status read. A lost coincident edge shows on the read that follows the colliding one.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int LINE_CNT  = 4;
    localparam int STAT_W    = 2 * LINE_CNT;
    localparam int CTL_W     = 3;
    localparam int ADDR_W    = 1;

    // Line index inside the status register (order is software visible)
    localparam int LN_CTS  = 0;
    localparam int LN_DSR  = 1;
    localparam int LN_RING = 2;
    localparam int LN_DCD  = 3;

    // Lines whose flag latches only on release (low to high)
    localparam logic [LINE_CNT-1:0] RELEASE_ONLY_MASK = 4'b0100;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTL  = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic irq_en;       // bit 2
        logic req_send_on;  // bit 1
        logic term_rdy_on;  // bit 0
    } ctl_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [LINE_CNT-1:0] level_n,
        input logic [LINE_CNT-1:0] flags
    );
        return {~level_n, flags};
    endfunction

    function automatic logic [STAT_W-1:0] pack_ctl(input ctl_t c);
        logic [STAT_W-1:0] v;
        v = '0;
        v[CTL_W-1:0] = c;
        return v;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
#(
    parameter int LINES = LINE_CNT,
    parameter logic [LINES-1:0] REL_ONLY = RELEASE_ONLY_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] cur_n,
    input  logic             clr,
    output logic [LINES-1:0] flags,
    output logic [LINES-1:0] events
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= cur_n;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (REL_ONLY[i]) begin : g_release
            assign events[i] = ~prev_q[i] & cur_n[i];
        end else begin : g_any
            assign events[i] = prev_q[i] ^ cur_n[i];
        end

        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= (flag_q[i] & ~clr) | events[i];
        end

        // R8: edge coincident with a clear survives
        assert_keep_on_collide_R8: assert property (@(posedge clk) disable iff (rst)
            (clr && events[i]) |=> flag_q[i]);

        // R7: clear without edge empties the flag
        assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
            (clr && !events[i]) |=> !flag_q[i]);

        if (REL_ONLY[i]) begin : g_chk_rel
            // R6: falling ring edge never sets a clear flag
            assert_ring_fall_ignored_R6: assert property (@(posedge clk) disable iff (rst)
                (!flag_q[i] && prev_q[i] && !cur_n[i]) |=> !flag_q[i]);
        end else begin : g_chk_any
            // R5: any transition sets the flag
            assert_any_edge_sets_R5: assert property (@(posedge clk) disable iff (rst)
                (prev_q[i] != cur_n[i]) |=> flag_q[i]);
        end
    end

    assign flags = flag_q;
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CTL_W-1:0]    wdata,
    input  logic [LINE_CNT-1:0] level_n,
    input  logic [LINE_CNT-1:0] flags,
    output logic [STAT_W-1:0]   rdata,
    output logic                stat_clr,
    output ctl_t                ctl
);
    ctl_t ctl_q;
    reg_addr_e sel;

    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst)                          ctl_q <= '0;
        else if (wr && sel == ADDR_CTL)   ctl_q <= ctl_t'(wdata);
    end

    always_comb begin
        unique case (sel)
            ADDR_CTL:  rdata = pack_ctl(ctl_q);
            ADDR_STAT: rdata = pack_status(level_n, flags);
            default:   rdata = '0;
        endcase
    end

    assign stat_clr = rd && (sel == ADDR_STAT);
    assign ctl      = ctl_q;

    // R10: a status write leaves the control register alone
    assert_stat_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == ADDR_STAT) |=> $stable(ctl_q));
endmodule

// File: rtl/mdm_handshake_unit.sv
module mdm_handshake_unit
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CTL_W-1:0]    reg_wdata,
    output logic [STAT_W-1:0]   reg_rdata,
    input  logic                loopback,
    input  logic                dsr_n,
    input  logic                cts_n,
    input  logic                dcd_n,
    input  logic                ring_n,
    output logic                term_rdy_n,
    output logic                req_send_n,
    output logic                irq
);
    logic [LINE_CNT-1:0] raw_n;
    logic [LINE_CNT-1:0] sync_n;
    logic [LINE_CNT-1:0] flags;
    logic [LINE_CNT-1:0] events;
    logic                stat_clr;
    ctl_t                ctl;

    always_comb begin
        raw_n          = '1;
        raw_n[LN_CTS]  = cts_n;
        raw_n[LN_DSR]  = dsr_n;
        raw_n[LN_RING] = ring_n;
        raw_n[LN_DCD]  = dcd_n;
    end

    mdm_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES), .RST_VAL('1)) sync_i (
        .clk (clk), .rst (rst), .din (raw_n), .dout (sync_n)
    );

    mdm_delta #(.LINES(LINE_CNT), .REL_ONLY(RELEASE_ONLY_MASK)) delta_i (
        .clk (clk), .rst (rst), .cur_n (sync_n), .clr (stat_clr),
        .flags (flags), .events (events)
    );

    mdm_regs regs_i (
        .clk (clk), .rst (rst), .wr (reg_wr), .rd (reg_rd), .addr (reg_addr),
        .wdata (reg_wdata), .level_n (sync_n), .flags (flags),
        .rdata (reg_rdata), .stat_clr (stat_clr), .ctl (ctl)
    );

    assign term_rdy_n = ~ctl.term_rdy_on | loopback;
    assign req_send_n = ~ctl.req_send_on | loopback;
    assign irq        = ctl.irq_en & (|flags);

    // R3: loopback parks both outputs idle
    assert_loopback_idle_R3: assert property (@(posedge clk) disable iff (rst)
        loopback |-> (term_rdy_n && req_send_n));

    // R9: a clearing read with no new edge drops the request
    assert_irq_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !(|events)) |=> !irq);

    // R1: first cycle after reset is quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!irq && term_rdy_n && req_send_n));
endmodule

// File: tb/mdm_handshake_unit_tb.sv
module mdm_handshake_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [0:0] reg_addr = '0;
    logic [2:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       loopback = 1'b0;
    logic       dsr_n = 1'b1, cts_n = 1'b1, dcd_n = 1'b1, ring_n = 1'b1;
    logic       term_rdy_n, req_send_n, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model: lines indexed cts0 dsr1 ring2 dcd3, active low
    logic [3:0] m_lines = 4'hF;
    logic [3:0] m_flags = 4'h0;
    logic [2:0] m_ctl   = 3'h0;
    logic       m_lb    = 1'b0;

    always #2.5 clk = ~clk;

    mdm_handshake_unit dut_i (
        .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .loopback, .dsr_n, .cts_n, .dcd_n, .ring_n,
        .term_rdy_n, .req_send_n, .irq
    );

    function automatic logic [7:0] exp_status();
        return {~m_lines, m_flags};
    endfunction
    function automatic logic exp_irq();
        return m_ctl[2] && (m_flags != 0);
    endfunction
    function automatic logic [3:0] new_flags(logic [3:0] o, logic [3:0] n);
        logic [3:0] f;
        f = m_flags;
        for (int i = 0; i < 4; i++) begin
            if (i == 2) begin
                if (!o[i] && n[i]) f[i] = 1'b1;
            end else if (o[i] != n[i]) f[i] = 1'b1;
        end
        return f;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_lines(input logic [3:0] v);
        cts_n = v[0]; dsr_n = v[1]; ring_n = v[2]; dcd_n = v[3];
    endtask

    task automatic wr_reg(input logic a, input logic [2:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        if (!a) m_ctl = d;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic set_lines(input logic [3:0] v);
        @(negedge clk); drive_lines(v);
        repeat (4) @(negedge clk);
        m_flags = new_flags(m_lines, v);
        m_lines = v;
    endtask

    task automatic check_pins(input string tag);
        logic [1:0] e;
        e[0] = m_lb | ~m_ctl[0];
        e[1] = m_lb | ~m_ctl[1];
        #1;
        check({req_send_n, term_rdy_n} == e, {tag, " R2/R3 outputs"}, {6'b0, req_send_n, term_rdy_n}, {6'b0, e});
        check(irq == exp_irq(), {tag, " R9 irq"}, {7'b0, irq}, {7'b0, exp_irq()});
    endtask

    task automatic check_status_read(input string tag);
        logic [7:0] d, e;
        e = exp_status();
        rd_reg(1'b1, d);
        check(d == e, {tag, " R4/R5/R6 status"}, d, e);
        m_flags = 4'h0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        process::self().srandom(32'h5eed_1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_reg(1'b0, d); check(d == 8'h00, "R1 ctl after reset", d, 8'h00);
        check_pins("R1");
        check_status_read("R1");

        // R2 each control bit separately
        wr_reg(1'b0, 3'b001); check_pins("R2 dtr");
        wr_reg(1'b0, 3'b010); check_pins("R2 rts");
        wr_reg(1'b0, 3'b011); check_pins("R2 both");

        // R3 loopback override and readback
        @(negedge clk); loopback = 1'b1; m_lb = 1'b1; check_pins("R3 lb on");
        rd_reg(1'b0, d); check(d == 8'h03, "R3 ctl retained", d, 8'h03);
        @(negedge clk); loopback = 1'b0; m_lb = 1'b0; check_pins("R3 lb off");

        // R10 write to status ignored, reserved bits zero
        wr_reg(1'b0, 3'b111);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 3'b000;
        @(negedge clk); reg_wr = 1'b0;
        rd_reg(1'b0, d); check(d == 8'h07, "R10 ctl after status write", d, 8'h07);
        check_status_read("R10");

        // R4/R5 latency on set-ready
        @(negedge clk); dsr_n = 1'b0;
        reg_addr = 1'b1;
        @(negedge clk); #1 check(reg_rdata[5] == 1'b0, "R4 level after 1 edge", reg_rdata, 8'h00);
        @(negedge clk); #1 check(reg_rdata[5] == 1'b1, "R4 level after 2 edges", reg_rdata, 8'h20);
        check(reg_rdata[1] == 1'b0, "R5 flag after 2 edges", reg_rdata, 8'h20);
        @(negedge clk); #1 check(reg_rdata[1] == 1'b1, "R5 flag after 3 edges", reg_rdata, 8'h22);
        check(irq == 1'b1, "R9 irq with flag", {7'b0, irq}, 8'h01);
        m_lines[1] = 1'b0; m_flags[1] = 1'b1;
        check_status_read("R5 dsr fall");
        check_pins("R7 after clear");
        rd_reg(1'b1, d); check(d[3:0] == 4'h0, "R7 flags cleared", d, {exp_status()});

        // R6 ring: assert then release
        set_lines(m_lines & 4'b1011); check_status_read("R6 ring fall");
        set_lines(m_lines | 4'b0100); check_status_read("R6 ring rise");

        // R8 edge in the read cycle
        @(negedge clk); cts_n = ~cts_n;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        m_lines[0] = cts_n; m_flags = 4'h1;
        check_status_read("R8 collide");

        // R9 irq enable off hides flags
        wr_reg(1'b0, 3'b011);
        set_lines(m_lines ^ 4'b1000); check_pins("R9 disabled");
        wr_reg(1'b0, 3'b111); check_pins("R9 enabled");
        check_status_read("R9");

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: set_lines(4'($urandom));
                1: wr_reg(1'b0, 3'($urandom));
                2: begin @(negedge clk); m_lb = 1'($urandom); loopback = m_lb; end
                default: check_status_read("rand");
            endcase
            check_pins("rand");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule